// File: doc/BRIEF.md
# Cascadable Dual Pulse Accumulator

This block holds two byte-wide event counters. Each counter advances by one on a single-cycle count strobe that has already been synchronised to the block clock. With the chain control low, the two counters run independently and wrap silently. With it high, they form one 16-bit accumulator. The lower byte takes the count strobe, and the upper byte advances in the same cycle that the lower byte rolls over.

Software reaches the counters through a register port. Each byte has its own write strobe, and a word write loads both bytes in one cycle, so a 16-bit value never passes through a half-updated state. Any write to a counter wins over a count strobe in the same cycle. A sticky overflow flag marks a rollover of the full 16-bit count. Software clears the flag by writing one to its clear strobe.

Top module: `pulse_acc_pair`

## Requirements
- R1: During and after reset, `cnt_lo`, `cnt_hi` and `ovf_flag` are all 0.
- R2: With `chain_en`=0, each counter advances by exactly one on the clock edge that samples its own strobe (`pulse_lo` for `cnt_lo`, `pulse_hi` for `cnt_hi`). It wraps from 0xFF to 0x00, and the other counter is left unchanged.
- R3: With `chain_en`=1, `pulse_hi` is ignored. `pulse_lo` advances `cnt_lo`, and `cnt_hi` advances on the same edge on which `cnt_lo` goes from 0xFF to 0x00.
- R4: With `chain_en`=1, a rollover of {`cnt_hi`,`cnt_lo`} from 0xFFFF to 0x0000 sets `ovf_flag` on that edge. The flag then stays at 1 until it is cleared.
- R5: `wr_lo_en` loads `wr_byte` into `cnt_lo`, and `wr_hi_en` loads `wr_byte` into `cnt_hi`, on the next edge. A count strobe or carry aimed at that byte in the same cycle is discarded.
- R6: `wr_word_en` loads `wr_word[15:8]` into `cnt_hi` and `wr_word[7:0]` into `cnt_lo` on one edge. It wins over the byte write strobes and over every count in that cycle.
- R7: `ovf_clr`=1 clears `ovf_flag` on the next edge. If an overflow occurs in the same cycle, the flag stays at 1.
- R8: With `chain_en`=0, no wrap of either counter changes `ovf_flag` from 0 to 1.
- R9: With `chain_en`=1, a write to `cnt_lo` that coincides with a `pulse_lo` while `cnt_lo` is 0xFF produces no carry, so `cnt_hi` keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pulse_lo | input | 1 | Single-cycle count strobe for the lower counter |
| pulse_hi | input | 1 | Single-cycle count strobe for the upper counter (unchained only) |
| chain_en | input | 1 | 1 joins the two counters into one 16-bit accumulator |
| wr_lo_en | input | 1 | Byte write strobe for the lower counter |
| wr_hi_en | input | 1 | Byte write strobe for the upper counter |
| wr_byte | input | 8 | Data for byte writes |
| wr_word_en | input | 1 | Word write strobe for both counters |
| wr_word | input | 16 | Data for word writes, upper byte in bits 15:8 |
| ovf_clr | input | 1 | Write-one strobe that clears the overflow flag |
| cnt_lo | output | 8 | Lower counter value |
| cnt_hi | output | 8 | Upper counter value |
| ovf_flag | output | 1 | Sticky 16-bit overflow flag |

## Verification
The assertions assume that every strobe is a clean synchronous level sampled once per clock edge, with no unknown values once reset is released. They also assume that the write data is relevant only while its strobe is high. The bench changes all inputs on the falling edge, drives them to 0 whenever a step does not use them, and holds `chain_en` steady for long runs so that carry and rollover paths are reached. Word writes in the random phase are biased toward values near 0xFFFF and 0x00FF, so carries, full rollovers and clear/overflow collisions occur often.

// File: rtl/pacc_pkg.sv
package pacc_pkg;
   localparam int unsigned LANES = 2;

   typedef enum logic [0:0] {
      LANE_LO = 1'b0,
      LANE_HI = 1'b1
   } lane_e;
endpackage

// File: rtl/pacc_byte_counter.sv
module pacc_byte_counter #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc_i,
   input  logic             load_i,
   input  logic [WIDTH-1:0] load_val_i,
   output logic [WIDTH-1:0] q_o,
   output logic             wrap_o
);
   localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
   localparam logic [WIDTH-1:0] ONE      = WIDTH'(1);

   if (WIDTH < 2) begin : g_bad_width
      $error("pacc_byte_counter: WIDTH must be at least 2");
   end

   logic [WIDTH-1:0] q_r;

   always_ff @(posedge clk) begin
      if (!rst_n)      q_r <= '0;
      else if (load_i) q_r <= load_val_i;
      else if (inc_i)  q_r <= q_r + ONE;
   end

   assign q_o    = q_r;
   assign wrap_o = inc_i && !load_i && (q_r == ALL_ONES);

   // R5 / R6: a load wins over a same-cycle increment
   p_load_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> q_o == $past(load_val_i));
   // R2: one step per accepted strobe
   p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !load_i) |=> q_o == $past(q_o) + ONE);
   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc_i && !load_i) |=> $stable(q_o));
endmodule

// File: rtl/pacc_sticky_flag.sv
module pacc_sticky_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   logic flag_r;

   always_ff @(posedge clk) begin
      if (!rst_n)     flag_r <= 1'b0;
      else if (set_i) flag_r <= 1'b1;
      else if (clr_i) flag_r <= 1'b0;
   end

   assign flag_o = flag_r;

   // R7: set wins over a same-cycle clear
   p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_o);
   p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !flag_o);
   // R4: sticky while untouched
   p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i && !clr_i) |=> $stable(flag_o));
endmodule

// File: rtl/pulse_acc_pair.sv
module pulse_acc_pair #(
   parameter int unsigned BYTE_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                pulse_lo,
   input  logic                pulse_hi,
   input  logic                chain_en,
   input  logic                wr_lo_en,
   input  logic                wr_hi_en,
   input  logic [BYTE_W-1:0]   wr_byte,
   input  logic                wr_word_en,
   input  logic [2*BYTE_W-1:0] wr_word,
   input  logic                ovf_clr,
   output logic [BYTE_W-1:0]   cnt_lo,
   output logic [BYTE_W-1:0]   cnt_hi,
   output logic                ovf_flag
);
   import pacc_pkg::*;

   localparam int unsigned    WORD_W   = 2 * BYTE_W;
   localparam logic [BYTE_W-1:0] BYTE_MAX = {BYTE_W{1'b1}};
   localparam logic [BYTE_W-1:0] ONE      = BYTE_W'(1);

   if (BYTE_W < 2 || BYTE_W > 32) begin : g_bad_byte_w
      $error("pulse_acc_pair: BYTE_W must lie in 2..32");
   end
   if (LANES != 2) begin : g_bad_lanes
      $error("pulse_acc_pair: exactly two lanes are supported");
   end

   logic [LANES-1:0]  lane_pulse;
   logic [LANES-1:0]  lane_wr;
   logic [LANES-1:0]  lane_inc;
   logic [LANES-1:0]  lane_load;
   logic [LANES-1:0]  lane_wrap;
   logic [BYTE_W-1:0] lane_val [LANES];
   logic [BYTE_W-1:0] lane_q   [LANES];

   assign lane_pulse[LANE_LO] = pulse_lo;
   assign lane_pulse[LANE_HI] = pulse_hi;
   assign lane_wr[LANE_LO]    = wr_lo_en;
   assign lane_wr[LANE_HI]    = wr_hi_en;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      // word write picks this lane's slice and outranks the byte strobe
      assign lane_load[g] = wr_word_en || lane_wr[g];
      assign lane_val[g]  = wr_word_en ? wr_word[g*BYTE_W +: BYTE_W] : wr_byte;

      if (g == 0) begin : g_base
         assign lane_inc[g] = lane_pulse[g];
      end else begin : g_cascade
         // chained: carry from the lane below replaces this lane's strobe
         assign lane_inc[g] = chain_en ? lane_wrap[g-1] : lane_pulse[g];
      end

      pacc_byte_counter #(.WIDTH(BYTE_W)) u_cnt (
         .clk        (clk),
         .rst_n      (rst_n),
         .inc_i      (lane_inc[g]),
         .load_i     (lane_load[g]),
         .load_val_i (lane_val[g]),
         .q_o        (lane_q[g]),
         .wrap_o     (lane_wrap[g])
      );
   end

   logic ovf_set;
   assign ovf_set = chain_en && lane_wrap[LANE_HI];

   pacc_sticky_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (ovf_set),
      .clr_i  (ovf_clr),
      .flag_o (ovf_flag)
   );

   assign cnt_lo = lane_q[LANE_LO];
   assign cnt_hi = lane_q[LANE_HI];

   // R3: carry into the upper byte on the lower byte's rollover edge
   p_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (chain_en && pulse_lo && cnt_lo == BYTE_MAX && !wr_lo_en && !wr_hi_en && !wr_word_en)
      |=> (cnt_hi == $past(cnt_hi) + ONE) && (cnt_lo == '0));
   // R3: upper strobe ignored when chained
   p_hi_strobe_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (chain_en && !pulse_lo && !wr_hi_en && !wr_word_en) |=> $stable(cnt_hi));
   // R8: no overflow flag from unchained wraps
   p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!chain_en && !ovf_flag) |=> !ovf_flag);
   // R9: a lower-byte write suppresses the carry
   p_write_blocks_carry_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (chain_en && wr_lo_en && !wr_hi_en && !wr_word_en) |=> $stable(cnt_hi));
   // R6: word write lands both bytes together
   p_word_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_word_en |=> {cnt_hi, cnt_lo} == $past(wr_word[WORD_W-1:0]));
endmodule

// File: tb/pulse_acc_pair_bench.sv
module pulse_acc_pair_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        pulse_lo, pulse_hi, chain_en;
   logic        wr_lo_en, wr_hi_en, wr_word_en, ovf_clr;
   logic [7:0]  wr_byte;
   logic [15:0] wr_word;
   logic [7:0]  cnt_lo, cnt_hi;
   logic        ovf_flag;

   int checks   = 0;
   int failures = 0;
   bit done     = 1'b0;

   logic [7:0] m_lo = 8'h00;
   logic [7:0] m_hi = 8'h00;
   logic       m_ovf = 1'b0;

   always #4 clk = ~clk;

   pulse_acc_pair u_pulse_acc_pair (
      .clk(clk), .rst_n(rst_n), .pulse_lo(pulse_lo), .pulse_hi(pulse_hi),
      .chain_en(chain_en), .wr_lo_en(wr_lo_en), .wr_hi_en(wr_hi_en),
      .wr_byte(wr_byte), .wr_word_en(wr_word_en), .wr_word(wr_word),
      .ovf_clr(ovf_clr), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .ovf_flag(ovf_flag)
   );

   task automatic check8(input string tag, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      check8(tag, "cnt_lo", cnt_lo, m_lo);
      check8(tag, "cnt_hi", cnt_hi, m_hi);
      check8(tag, "ovf_flag", {7'd0, ovf_flag}, {7'd0, m_ovf});
   endtask

   // expected state after one edge, derived from R2..R9
   task automatic model_step();
      logic lo_ld, hi_ld, lo_roll, hi_inc, hi_roll;
      logic [7:0] n_lo, n_hi;
      lo_ld   = wr_word_en | wr_lo_en;
      hi_ld   = wr_word_en | wr_hi_en;
      lo_roll = !lo_ld && pulse_lo && (m_lo == 8'hFF);
      hi_inc  = chain_en ? lo_roll : pulse_hi;
      hi_roll = !hi_ld && hi_inc && (m_hi == 8'hFF);
      n_lo = wr_word_en ? wr_word[7:0]  : wr_lo_en ? wr_byte : pulse_lo ? m_lo + 8'd1 : m_lo;
      n_hi = wr_word_en ? wr_word[15:8] : wr_hi_en ? wr_byte : hi_inc   ? m_hi + 8'd1 : m_hi;
      m_ovf = (chain_en && hi_roll) ? 1'b1 : (ovf_clr ? 1'b0 : m_ovf);
      m_lo  = n_lo;
      m_hi  = n_hi;
   endtask

   task automatic idle_inputs();
      pulse_lo = 0; pulse_hi = 0; wr_lo_en = 0; wr_hi_en = 0;
      wr_word_en = 0; ovf_clr = 0; wr_byte = 8'h00; wr_word = 16'h0000;
   endtask

   // called at a falling edge with inputs already set
   task automatic cycle(input string tag);
      model_step();
      @(negedge clk);
      check_all(tag);
      idle_inputs();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      rst_n = 0; chain_en = 0;
      idle_inputs();
      repeat (3) @(negedge clk);
      check_all("R1");
      rst_n = 1;
      @(negedge clk);
      check_all("R1");

      // R2 / R8: unchained wraps, independent lanes
      wr_lo_en = 1; wr_byte = 8'hFE; cycle("R5");
      pulse_lo = 1; cycle("R2");
      pulse_lo = 1; pulse_hi = 1; cycle("R2");
      wr_hi_en = 1; wr_byte = 8'hFF; cycle("R5");
      pulse_hi = 1; cycle("R8");

      // R3: carry into upper byte, upper strobe ignored
      chain_en = 1;
      pulse_hi = 1; cycle("R3");
      wr_word_en = 1; wr_word = 16'h00FF; cycle("R6");
      pulse_lo = 1; pulse_hi = 1; cycle("R3");

      // R4: full rollover sets the sticky flag
      wr_word_en = 1; wr_word = 16'hFFFF; cycle("R6");
      pulse_lo = 1; cycle("R4");
      cycle("R4");

      // R7: clear colliding with a fresh overflow, then a lone clear
      wr_word_en = 1; wr_word = 16'hFFFF; cycle("R6");
      pulse_lo = 1; ovf_clr = 1; cycle("R7");
      ovf_clr = 1; cycle("R7");

      // R5 / R9: writes beat counts and block the carry
      wr_lo_en = 1; wr_byte = 8'hFF; cycle("R5");
      pulse_lo = 1; wr_lo_en = 1; wr_byte = 8'h10; cycle("R9");
      wr_word_en = 1; wr_word = 16'hA5FF; wr_hi_en = 1; wr_lo_en = 1;
      wr_byte = 8'h33; pulse_lo = 1; cycle("R6");

      // constrained random mix
      for (int i = 0; i < 4000; i++) begin
         if ($urandom_range(99) < 2) chain_en = ~chain_en;
         pulse_lo = ($urandom_range(99) < 60);
         pulse_hi = ($urandom_range(99) < 40);
         wr_lo_en = ($urandom_range(99) < 4);
         wr_hi_en = ($urandom_range(99) < 4);
         wr_byte  = 8'($urandom);
         wr_word_en = ($urandom_range(99) < 3);
         case ($urandom_range(2))
            0: wr_word = 16'hFFF0 | 16'($urandom_range(15));
            1: wr_word = 16'h00F0 | 16'($urandom_range(15));
            default: wr_word = 16'($urandom);
         endcase
         ovf_clr = ($urandom_range(99) < 5);
         cycle(wr_word_en ? "R6" : (wr_lo_en || wr_hi_en) ? "R5" :
               chain_en ? "R3" : "R2");
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule